// File: doc/BRIEF.md
# Weighted Slot Round-Robin Arbiter

This block picks which of several requesters may use one address channel. Its priority order is a circular list of slots fixed at elaboration. Each slot names one requester, and a requester may own several slots. Over a long run, a requester that keeps asking receives grants in proportion to the number of slots it owns. The order never changes at run time. Only a pointer to the slot at the top of the list moves.

The decision is registered. The winner picked from the current requests drives the grant outputs one cycle later. The list rotates by exactly one place on every real grant to an active requester. When nothing is asking, the grant parks on the owner of the top slot. That parked grant is not a real grant, and it does not move the list. An eligibility mask, enabled by a separate input, limits which requesters may take part. While the mask is enabled, the bus is never parked.

A combinational read-back port returns the owner of any slot, so software or a bench can find the fixed order.

Top module: `wsrr_arbiter`

## Requirements
- R1: After reset, the head pointer is slot 0. The grant is parked on the owner of slot 0, with `gnt_dflt`=1 and `gnt_real`=0.
- R2: A requester is active when its `req_valid` bit is high and, if `qos_en` is high, its `qos_mask` bit is also high. The winner is the active requester that owns the first slot reached when scanning from the head slot in increasing slot order, wrapping at the last slot. That winner appears on `gnt_idx` with `gnt_real`=1 in the following cycle.
- R3: A real grant that is not a claim of a parked grant advances the head pointer by one, from the last slot back to slot 0. Every slot shifts up one place and the order is otherwise kept.
- R4: With no active requester and `qos_en` low, the next cycle shows `gnt_dflt`=1 and `gnt_real`=0, with `gnt_idx` equal to the owner of the head slot. The head pointer does not move.
- R5: If the grant is parked and the parked requester is the winner, it takes a real grant in the next cycle and the head pointer does not move.
- R6: A requester whose mask bit is clear while `qos_en` is high is never granted. With `qos_en` high and no active requester, the next cycle has `gnt_onehot`=0, `gnt_real`=0 and `gnt_dflt`=0, and the head pointer holds.
- R7: With every requester asking continuously, each requester receives exactly as many real grants as it owns slots in every run of grants that is a whole multiple of the slot count.
- R8: `rd_owner` carries the owner number of slot `rd_slot` in its low bits, zero-extended to 8 bits. It reads 0 for a slot number at or beyond the slot count. The values never change during operation.
- R9: `gnt_onehot` has bit `gnt_idx` set when `gnt_real` or `gnt_dflt` is high, and is zero otherwise. `gnt_real` and `gnt_dflt` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Request from each requester |
| qos_en | input | 1 | Enables the eligibility mask |
| qos_mask | input | NUM_REQ | Eligibility bit for each requester |
| rd_slot | input | SW | Slot number to read back |
| gnt_onehot | output | NUM_REQ | One-hot grant, zero when nothing is granted |
| gnt_idx | output | IW | Number of the granted requester |
| gnt_real | output | 1 | The grant went to an active requester |
| gnt_dflt | output | 1 | The grant is parked on an idle bus |
| head_slot | output | SW | Slot currently at the top of the list |
| rd_owner | output | 8 | Owner of slot `rd_slot` |

## Verification
The delicate case is a parked grant meeting a new request in the same cycle. A claim by the parked requester must turn the grant into a real one without rotating the list. A request from any other requester must rotate the list. The directed table produces both outcomes from a parked state and checks the head pointer after each one. In the long random run, the mask is switched on and off while the bus is often idle, so parking, claims and masked idle cycles meet in every combination. Each cycle is compared against a bench model that keeps an explicitly rotated list.

// File: rtl/wsrr_pkg.sv
package wsrr_pkg;

  // advance a slot position by one, wrapping at lim
  function automatic int wrap_inc(input int pos, input int lim);
    return (pos + 1 >= lim) ? 0 : pos + 1;
  endfunction

  // slot position reached k steps after base, wrapping at lim
  function automatic int wrap_add(input int base, input int k, input int lim);
    int s;
    s = base + k;
    return (s >= lim) ? s - lim : s;
  endfunction

endpackage

// File: rtl/wsrr_slot_table.sv
module wsrr_slot_table #(
  parameter int NUM_REQ = 4,
  parameter int NUM_SLOTS = 6,
  parameter logic [NUM_SLOTS*8-1:0] SLOT_OWNERS = '0,
  parameter int IW = 2,
  parameter int SW = 3
) (
  input  logic [SW-1:0]           rd_slot,
  output logic [NUM_SLOTS*IW-1:0] owner_flat,
  output logic [7:0]              rd_owner
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign owner_flat[g*IW +: IW] = SLOT_OWNERS[g*8 +: IW];
  end

  // read-only view; out-of-range slots return zero
  always_comb begin
    rd_owner = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (int'(rd_slot) == k) rd_owner = SLOT_OWNERS[k*8 +: 8];
    end
  end

endmodule

// File: rtl/wsrr_pick.sv
module wsrr_pick #(
  parameter int NUM_REQ = 4,
  parameter int NUM_SLOTS = 6,
  parameter int IW = 2,
  parameter int SW = 3
) (
  input  logic [NUM_REQ-1:0]      active,
  input  logic [SW-1:0]           head,
  input  logic [NUM_SLOTS*IW-1:0] owner_flat,
  output logic                    found,
  output logic [IW-1:0]           win_idx,
  output logic [IW-1:0]           head_owner
);
  import wsrr_pkg::*;

  assign head_owner = owner_flat[int'(head)*IW +: IW];

  // scan slots from the head, first active owner wins
  always_comb begin
    int p;
    logic [IW-1:0] o;
    found   = 1'b0;
    win_idx = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      p = wrap_add(int'(head), k, NUM_SLOTS);
      o = owner_flat[p*IW +: IW];
      if (!found && active[o]) begin
        found   = 1'b1;
        win_idx = o;
      end
    end
  end

endmodule

// File: rtl/wsrr_state.sv
module wsrr_state #(
  parameter int NUM_SLOTS = 6,
  parameter int IW = 2,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qos_en,
  input  logic          found,
  input  logic [IW-1:0] win_idx,
  input  logic [IW-1:0] head_owner,
  input  logic [IW-1:0] reset_owner,
  output logic [SW-1:0] head,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_real,
  output logic          gnt_dflt,
  output logic          evt_rotate,
  output logic          evt_claim
);
  import wsrr_pkg::*;

  // parked requester becomes active: grant turns real, list stays
  assign evt_claim  = found & gnt_dflt & (win_idx == gnt_idx);
  assign evt_rotate = found & ~evt_claim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      gnt_idx  <= reset_owner;
      gnt_real <= 1'b0;
      gnt_dflt <= 1'b1;
    end else if (found) begin
      gnt_real <= 1'b1;
      gnt_dflt <= 1'b0;
      if (evt_rotate) begin
        gnt_idx <= win_idx;
        head    <= SW'(wrap_inc(int'(head), NUM_SLOTS));
      end
    end else if (qos_en) begin
      gnt_real <= 1'b0;
      gnt_dflt <= 1'b0;
    end else begin
      gnt_real <= 1'b0;
      gnt_dflt <= 1'b1;
      gnt_idx  <= head_owner;
    end
  end

endmodule

// File: rtl/wsrr_arbiter.sv
module wsrr_arbiter #(
  parameter int NUM_REQ = 4,
  parameter int NUM_SLOTS = 6,
  parameter logic [NUM_SLOTS*8-1:0] SLOT_OWNERS = 48'h00_03_02_00_01_00,
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_valid,
  input  logic               qos_en,
  input  logic [NUM_REQ-1:0] qos_mask,
  input  logic [SW-1:0]      rd_slot,
  output logic [NUM_REQ-1:0] gnt_onehot,
  output logic [IW-1:0]      gnt_idx,
  output logic               gnt_real,
  output logic               gnt_dflt,
  output logic [SW-1:0]      head_slot,
  output logic [7:0]         rd_owner
);

  logic [NUM_SLOTS*IW-1:0] owner_flat;
  logic [NUM_REQ-1:0]      active;
  logic                    win_found;
  logic [IW-1:0]           win_idx;
  logic [IW-1:0]           head_owner;
  logic                    evt_rotate;
  logic                    evt_claim;

  assign active = req_valid & (qos_en ? qos_mask : {NUM_REQ{1'b1}});

  wsrr_slot_table #(
    .NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS), .SLOT_OWNERS(SLOT_OWNERS),
    .IW(IW), .SW(SW)
  ) u_table (
    .rd_slot(rd_slot), .owner_flat(owner_flat), .rd_owner(rd_owner)
  );

  wsrr_pick #(
    .NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS), .IW(IW), .SW(SW)
  ) u_pick (
    .active(active), .head(head_slot), .owner_flat(owner_flat),
    .found(win_found), .win_idx(win_idx), .head_owner(head_owner)
  );

  wsrr_state #(
    .NUM_SLOTS(NUM_SLOTS), .IW(IW), .SW(SW)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .qos_en(qos_en), .found(win_found),
    .win_idx(win_idx), .head_owner(head_owner),
    .reset_owner(owner_flat[IW-1:0]), .head(head_slot), .gnt_idx(gnt_idx),
    .gnt_real(gnt_real), .gnt_dflt(gnt_dflt),
    .evt_rotate(evt_rotate), .evt_claim(evt_claim)
  );

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_oh
    assign gnt_onehot[i] = (gnt_real | gnt_dflt) && (int'(gnt_idx) == i);
  end

endmodule

// File: rtl/wsrr_arbiter_chk.sv
module wsrr_arbiter_chk #(
  parameter int NUM_REQ = 4,
  parameter int NUM_SLOTS = 6,
  parameter int SW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               qos_en,
  input logic               win_found,
  input logic               evt_rotate,
  input logic               evt_claim,
  input logic [SW-1:0]      head_slot,
  input logic [NUM_REQ-1:0] gnt_onehot,
  input logic               gnt_real,
  input logic               gnt_dflt
);
  import wsrr_pkg::*;

  p_found_grants_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_found |=> (gnt_real && !gnt_dflt));

  p_rotate_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rotate |=> (int'(head_slot) == wrap_inc(int'($past(head_slot)), NUM_SLOTS)));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_found |=> $stable(head_slot));

  p_idle_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_found && !qos_en) |=> (gnt_dflt && !gnt_real));

  p_claim_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_claim |=> ($stable(head_slot) && gnt_real));

  p_qos_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_found && qos_en) |=> (gnt_onehot == '0));

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_onehot));

  p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_real && gnt_dflt));

endmodule

bind wsrr_arbiter wsrr_arbiter_chk #(
  .NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .qos_en(qos_en), .win_found(win_found),
  .evt_rotate(evt_rotate), .evt_claim(evt_claim), .head_slot(head_slot),
  .gnt_onehot(gnt_onehot), .gnt_real(gnt_real), .gnt_dflt(gnt_dflt)
);

// File: tb/wsrr_arbiter_tb.sv
module wsrr_arbiter_tb;
  localparam int NR = 4;
  localparam int NS = 6;
  localparam logic [NS*8-1:0] OWN = 48'h00_03_02_00_01_00;
  localparam int STEPS = 17;
  // {tag4, req4, qos_en, mask4, idx2, real, dflt, head3}
  localparam logic [19:0] TBL [STEPS] = '{
    {4'd4, 4'b0000, 1'b0, 4'b0000, 2'd0, 1'b0, 1'b1, 3'd0}, // R4 park
    {4'd5, 4'b0001, 1'b0, 4'b0000, 2'd0, 1'b1, 1'b0, 3'd0}, // R5 claim
    {4'd3, 4'b0001, 1'b0, 4'b0000, 2'd0, 1'b1, 1'b0, 3'd1}, // R3
    {4'd2, 4'b0001, 1'b0, 4'b0000, 2'd0, 1'b1, 1'b0, 3'd2}, // R2
    {4'd2, 4'b0100, 1'b0, 4'b0000, 2'd2, 1'b1, 1'b0, 3'd3},
    {4'd2, 4'b1000, 1'b0, 4'b0000, 2'd3, 1'b1, 1'b0, 3'd4},
    {4'd4, 4'b0000, 1'b0, 4'b0000, 2'd3, 1'b0, 1'b1, 3'd4},
    {4'd2, 4'b0010, 1'b0, 4'b0000, 2'd1, 1'b1, 1'b0, 3'd5},
    {4'd6, 4'b1111, 1'b1, 4'b0010, 2'd1, 1'b1, 1'b0, 3'd0}, // R6
    {4'd6, 4'b0001, 1'b1, 4'b0010, 2'd1, 1'b0, 1'b0, 3'd0},
    {4'd4, 4'b0000, 1'b0, 4'b0000, 2'd0, 1'b0, 1'b1, 3'd0},
    {4'd2, 4'b0110, 1'b0, 4'b0000, 2'd1, 1'b1, 1'b0, 3'd1},
    {4'd3, 4'b0110, 1'b0, 4'b0000, 2'd1, 1'b1, 1'b0, 3'd2},
    {4'd2, 4'b0110, 1'b0, 4'b0000, 2'd2, 1'b1, 1'b0, 3'd3},
    {4'd6, 4'b0000, 1'b1, 4'b1111, 2'd2, 1'b0, 1'b0, 3'd3},
    {4'd4, 4'b0000, 1'b0, 4'b0000, 2'd2, 1'b0, 1'b1, 3'd3},
    {4'd5, 4'b0100, 1'b0, 4'b0000, 2'd2, 1'b1, 1'b0, 3'd3}
  };
  int owners [NS] = '{0, 1, 0, 2, 3, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] req_valid = '0;
  logic qos_en = 1'b0;
  logic [NR-1:0] qos_mask = '0;
  logic [2:0] rd_slot = '0;
  logic [NR-1:0] gnt_onehot;
  logic [1:0] gnt_idx;
  logic gnt_real, gnt_dflt;
  logic [2:0] head_slot;
  logic [7:0] rd_owner;
  int checks = 0;
  int errors = 0;

  wsrr_arbiter #(.NUM_REQ(NR), .NUM_SLOTS(NS), .SLOT_OWNERS(OWN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .qos_en(qos_en),
    .qos_mask(qos_mask), .rd_slot(rd_slot), .gnt_onehot(gnt_onehot),
    .gnt_idx(gnt_idx), .gnt_real(gnt_real), .gnt_dflt(gnt_dflt),
    .head_slot(head_slot), .rd_owner(rd_owner)
  );

  always #5 clk = ~clk;

  function automatic string rq(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input int idx, input int rl,
                             input int df, input int hd);
    int oh;
    oh = (rl != 0 || df != 0) ? (1 << idx) : 0;
    chk(tag, "gnt_real", int'(gnt_real), rl);
    chk(tag, "gnt_dflt", int'(gnt_dflt), df);
    chk(tag, "head_slot", int'(head_slot), hd);
    chk("R9", "gnt_onehot", int'(gnt_onehot), oh);
    if (rl != 0 || df != 0) chk(tag, "gnt_idx", int'(gnt_idx), idx);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = '0; qos_en = 1'b0; qos_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt [NR];
    int wgt [NR];
    int lst [NS];
    int m_idx, m_real, m_dflt, m_head;
    logic [NR-1:0] act;
    int hit;
    int t0;

    // R1: reset state
    do_reset();
    check_state("R1", owners[0], 0, 1, 0);

    // table walk: drive at negedge, check one edge later
    for (int s = 0; s < STEPS; s++) begin
      req_valid = TBL[s][15:12];
      qos_en    = TBL[s][11];
      qos_mask  = TBL[s][10:7];
      @(negedge clk);
      check_state(rq(int'(TBL[s][19:16])), int'(TBL[s][6:5]), int'(TBL[s][4]),
                  int'(TBL[s][3]), int'(TBL[s][2:0]));
    end

    // R8: read-back of every slot, after grant activity
    for (int s = 0; s < 8; s++) begin
      rd_slot = 3'(s);
      #1;
      chk("R8", "rd_owner", int'(rd_owner), (s < NS) ? owners[s] : 0);
    end

    // R7: shares with all requesters asking
    do_reset();
    for (int r = 0; r < NR; r++) begin cnt[r] = 0; wgt[r] = 0; end
    for (int s = 0; s < NS; s++) wgt[owners[s]]++;
    req_valid = '1;
    @(negedge clk);
    chk("R5", "claim head_slot", int'(head_slot), 0);
    for (int c = 0; c < NS * 10; c++) begin
      @(negedge clk);
      if (gnt_real) cnt[gnt_idx]++;
    end
    for (int r = 0; r < NR; r++) chk("R7", $sformatf("share of %0d", r), cnt[r], wgt[r] * 10);

    // random run against a rotating-list model (R2, R3, R4, R5, R6)
    do_reset();
    for (int s = 0; s < NS; s++) lst[s] = owners[s];
    m_idx = owners[0]; m_real = 0; m_dflt = 1; m_head = 0;
    for (int n = 0; n < 3000; n++) begin
      req_valid = 4'($urandom);
      if (($urandom % 3) == 0) req_valid = '0;
      qos_en    = (($urandom % 4) == 0);
      qos_mask  = 4'($urandom);
      act = req_valid & (qos_en ? qos_mask : 4'hF);
      hit = -1;
      for (int k = 0; k < NS; k++) if (hit < 0 && act[lst[k]]) hit = k;
      if (hit >= 0) begin
        if (m_dflt != 0 && hit == 0) begin
          m_real = 1; m_dflt = 0;
        end else begin
          m_idx = lst[hit]; m_real = 1; m_dflt = 0;
          t0 = lst[0];
          for (int k = 0; k < NS - 1; k++) lst[k] = lst[k+1];
          lst[NS-1] = t0;
          m_head = (m_head + 1) % NS;
        end
      end else if (qos_en) begin
        m_real = 0; m_dflt = 0;
      end else begin
        m_real = 0; m_dflt = 1; m_idx = lst[0];
      end
      @(negedge clk);
      check_state((hit >= 0) ? "R2" : (qos_en ? "R6" : "R4"), m_idx, m_real, m_dflt, m_head);
      if (gnt_real) chk("R6", "granted requester was eligible", int'(act[gnt_idx]), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule